// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block is the enhanced-mode part of a host-side printer port. A host reaches it through a small register window. Offset 3 starts an address cycle. Offset 4 starts a data cycle that is 1, 2 or 4 bytes wide. Offsets 0 to 2 hold the data latch, the status view and the control register, since the cycles depend on them.

Before any cycle starts, the block compares five control bits with a fixed pattern for the requested direction. If they do not match, the access finishes at once and the peripheral lines do not move. If they match, the block runs a two-phase handshake for each byte:

- It sets the write/read line and lowers the address or the data strobe.
- It waits for the peripheral's wait line to rise, then releases the strobe.
- It waits for the wait line to fall again.

A programmable cycle limit bounds each wait phase. When the limit runs out, the access is abandoned and a sticky timeout flag is raised. Software sees that flag in status bit 0.

Top module: `epp_gate`

## Requirements
- R1: After reset:
  - `ready` is high.
  - All three handshake outputs are high.
  - The control register reads 0xCC.
  - Status bit 0 reads 0.
- R2: A write to offset 2 stores the written byte with bits 7 and 6 forced to 1. A read of offset 2 returns the stored byte.
- R3: A write at offset 3 or 4 runs byte cycles only when control bits {5,3,2,1,0} equal 0b00100, which is bit 2 alone. Otherwise it completes with no strobe and no change to the timeout flag.
- R4: A read at offset 3 or 4 runs byte cycles only when control bits {5,3,2,1,0} equal 0b10100, which is bits 5 and 2. Otherwise no strobe occurs and `rdata` is all ones at the access width, with the upper bits 0:
  - size 0 returns 0x000000FF.
  - size 1 returns 0x0000FFFF.
  - size 2 returns 0xFFFFFFFF.
- R5: Each byte cycle works as follows:
  - `n_write` is low for writes and high for reads.
  - `n_astrb` (offset 3) or `n_dstrb` (offset 4) goes low, and never both at once.
  - The strobe stays low until `n_wait` is seen high.
  - The cycle ends when `n_wait` is seen low.
- R6: At offset 4 the `size` input selects 1, 2 or 4 bytes (0, 1, 2). Bytes are sent lowest first, and read bytes are placed lowest first. Offset 3 always moves one byte.
- R7: A wait phase that lasts longer than `tmo_limit`+1 cycles does three things:
  - It sets the timeout flag.
  - It releases the strobe.
  - It abandons the remaining bytes and completes the access.

  Bytes that were not read return as 0xFF. The flag stays set until it is cleared.
- R8: A read of offset 1 returns {`per_status`[7:1], timeout flag}.
- R9: A write to offset 1 with bit 0 set clears the timeout flag. With bit 0 clear, the write leaves the flag unchanged.
- R10: `ready` is low from the acceptance of a cycling access until its `ack`. A request made while `ready` is low is ignored.
- R11: A write to offset 0 stores the data byte. A read of offset 0 returns that byte when control bit 5 is 0, and `pd_in` when bit 5 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host access request, taken when `ready` is high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register offset |
| size | input | 2 | Width at offset 4: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| wdata | input | 32 | Write value, little-endian for wide writes |
| ready | output | 1 | Block can accept an access |
| ack | output | 1 | One-cycle pulse when an access completes |
| rdata | output | 32 | Read result, valid with `ack` |
| tmo_limit | input | CW | Wait-phase limit in cycles, minus one |
| per_status | input | 8 | Peripheral status lines |
| pd_in | input | 8 | Peripheral data bus in |
| n_wait | input | 1 | Peripheral wait/handshake line |
| pd_out | output | 8 | Peripheral data bus out |
| pd_oe | output | 1 | Data bus output enable |
| n_write | output | 1 | Low during write cycles |
| n_astrb | output | 1 | Address strobe, active low |
| n_dstrb | output | 1 | Data strobe, active low |

## Verification
The assertions assume two things about the inputs. First, `n_wait` is a synchronous level sampled once per clock. Second, the host changes `req`, `we`, `addr` and `wdata` only between clock edges. The sticky-flag property also assumes that a status write can reach the flag only through an accepted request.

The bench meets these conditions as follows:
- The peripheral model changes `n_wait` and `pd_in` only on the falling edge, after a random delay of 0 to 3 cycles, well inside the programmed limit.
- The host drives requests on the falling edge and waits for `ready` before each one.
- Peripheral modes that hold `n_wait` stuck are used only in the directed timeout cases, and the line is let go before the next access.

// File: rtl/epp_gate.sv
module epp_gate #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [1:0]    size,
  input  logic [31:0]   wdata,
  output logic          ready,
  output logic          ack,
  output logic [31:0]   rdata,
  input  logic [CW-1:0] tmo_limit,
  input  logic [7:0]    per_status,
  input  logic [7:0]    pd_in,
  input  logic          n_wait,
  output logic [7:0]    pd_out,
  output logic          pd_oe,
  output logic          n_write,
  output logic          n_astrb,
  output logic          n_dstrb
);

  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd1;
  localparam logic [2:0] OFF_CTRL = 3'd2;
  localparam logic [2:0] OFF_EADR = 3'd3;
  localparam logic [2:0] OFF_EDAT = 3'd4;
  localparam logic [7:0] MODE_MASK = 8'h2F;
  localparam logic [7:0] MODE_WR   = 8'h04;
  localparam logic [7:0] MODE_RD   = 8'h24;
  localparam logic [7:0] CTRL_RST  = 8'hCC;
  localparam logic [7:0] CTRL_HI   = 8'hC0;

  typedef enum logic [1:0] {S_IDLE, S_STRB, S_REL} st_t;

  st_t          st;
  logic [7:0]   ctrl_q, dataw_q;
  logic         tmo_q;
  logic [CW-1:0] cnt;
  logic [1:0]   idx, last;
  logic         cyc_wr, cyc_adr;
  logic [31:0]  wbuf, rbuf;

  logic         accept, is_epp, mode_ok, expired;
  logic [1:0]   nb_last;
  logic [31:0]  ones, reg_rd;

  assign ready   = (st == S_IDLE);
  assign accept  = req && ready;
  assign is_epp  = (addr == OFF_EADR) || (addr == OFF_EDAT);
  assign mode_ok = we ? ((ctrl_q & MODE_MASK) == MODE_WR)
                      : ((ctrl_q & MODE_MASK) == MODE_RD);
  assign expired = (cnt == tmo_limit);

  always_comb begin
    if (addr == OFF_EDAT && size == 2'd1)      nb_last = 2'd1;
    else if (addr == OFF_EDAT && size[1])      nb_last = 2'd3;
    else                                       nb_last = 2'd0;
  end

  always_comb begin
    case (nb_last)
      2'd1:    ones = 32'h0000_FFFF;
      2'd3:    ones = 32'hFFFF_FFFF;
      default: ones = 32'h0000_00FF;
    endcase
  end

  always_comb begin
    case (addr)
      OFF_DATA: reg_rd = {24'h0, ctrl_q[5] ? pd_in : dataw_q};
      OFF_STAT: reg_rd = {24'h0, per_status[7:1], tmo_q};
      OFF_CTRL: reg_rd = {24'h0, ctrl_q};
      OFF_EADR,
      OFF_EDAT: reg_rd = ones;
      default:  reg_rd = 32'h0000_00FF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ctrl_q  <= CTRL_RST;
      dataw_q <= 8'hFF;
      tmo_q   <= 1'b0;
      cnt     <= '0;
      idx     <= 2'd0;
      last    <= 2'd0;
      cyc_wr  <= 1'b0;
      cyc_adr <= 1'b0;
      wbuf    <= 32'h0;
      rbuf    <= 32'h0;
      ack     <= 1'b0;
      rdata   <= 32'h0;
    end else begin
      ack <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            if (is_epp && mode_ok) begin
              st      <= S_STRB;
              cnt     <= '0;
              idx     <= 2'd0;
              last    <= nb_last;
              cyc_wr  <= we;
              cyc_adr <= (addr == OFF_EADR);
              wbuf    <= wdata;
              rbuf    <= ones;
            end else begin
              ack   <= 1'b1;
              rdata <= reg_rd;
              if (we) begin
                case (addr)
                  OFF_DATA: dataw_q <= wdata[7:0];
                  OFF_STAT: if (wdata[0]) tmo_q <= 1'b0;
                  OFF_CTRL: ctrl_q  <= wdata[7:0] | CTRL_HI;
                  default: ;
                endcase
              end
            end
          end
        end
        S_STRB: begin
          if (n_wait) begin
            st  <= S_REL;
            cnt <= '0;
            if (!cyc_wr) rbuf[{idx, 3'b000} +: 8] <= pd_in;
          end else if (expired) begin
            tmo_q <= 1'b1;
            st    <= S_IDLE;
            ack   <= 1'b1;
            rdata <= rbuf;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REL: begin
          if (!n_wait) begin
            cnt <= '0;
            if (idx == last) begin
              st    <= S_IDLE;
              ack   <= 1'b1;
              rdata <= rbuf;
            end else begin
              idx <= idx + 1'b1;
              st  <= S_STRB;
            end
          end else if (expired) begin
            tmo_q <= 1'b1;
            st    <= S_IDLE;
            ack   <= 1'b1;
            rdata <= rbuf;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign pd_oe   = (st != S_IDLE) ? cyc_wr : !ctrl_q[5];
  assign pd_out  = (st != S_IDLE && cyc_wr) ? wbuf[{idx, 3'b000} +: 8] : dataw_q;
  assign n_write = !((st != S_IDLE) && cyc_wr);
  assign n_astrb = !((st == S_STRB) && cyc_adr);
  assign n_dstrb = !((st == S_STRB) && !cyc_adr);

endmodule

module epp_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        we,
  input logic [2:0]  addr,
  input logic [31:0] wdata,
  input logic        ready,
  input logic        ack,
  input logic        n_astrb,
  input logic        n_dstrb,
  input logic        n_write,
  input logic        pd_oe,
  input logic        tmo_q
);
  logic clr_wr;
  assign clr_wr = req && ready && we && (addr == 3'd1) && wdata[0];

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(!n_astrb && !n_dstrb)); // R5
  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) !n_write |-> pd_oe); // R5
  AST_BUSY_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (!n_astrb || !n_dstrb) |-> !ready); // R10
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) ack |-> ready); // R10
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (tmo_q && !clr_wr) |=> tmo_q); // R7
  AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr_wr |=> !tmo_q); // R9
endmodule

bind epp_gate epp_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
  .ready(ready), .ack(ack), .n_astrb(n_astrb), .n_dstrb(n_dstrb),
  .n_write(n_write), .pd_oe(pd_oe), .tmo_q(tmo_q)
);

// File: tb/tb_epp_gate.sv
module tb_epp_gate;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [2:0] addr = 0;
  logic [1:0] size = 0;
  logic [31:0] wdata = 0;
  logic ready, ack;
  logic [31:0] rdata;
  logic [7:0] tmo_limit = 8'd6;
  logic [7:0] per_status = 8'h00;
  logic [7:0] pd_in = 8'h00;
  logic n_wait = 0;
  logic [7:0] pd_out;
  logic pd_oe, n_write, n_astrb, n_dstrb;

  int nchk = 0, nfail = 0;
  int mode = 0, dly = 0, pcnt = 0, nlog = 0;
  logic [7:0] log_b [8];
  logic       log_a [8];
  logic       log_w [8];

  always #(CLK_P/2) clk = ~clk;

  epp_gate dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
    .wdata(wdata), .ready(ready), .ack(ack), .rdata(rdata), .tmo_limit(tmo_limit),
    .per_status(per_status), .pd_in(pd_in), .n_wait(n_wait), .pd_out(pd_out),
    .pd_oe(pd_oe), .n_write(n_write), .n_astrb(n_astrb), .n_dstrb(n_dstrb)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      n_wait = 0; pcnt = 0;
    end else if ((!n_astrb || !n_dstrb) && !n_wait) begin
      if (mode != 1) begin
        if (pcnt >= dly) begin
          pcnt = 0;
          if (n_write) pd_in = 8'($urandom);
          if (nlog < 8) begin
            log_b[nlog] = n_write ? pd_in : pd_out;
            log_a[nlog] = !n_astrb;
            log_w[nlog] = n_write;
          end
          nlog++;
          n_wait = 1;
        end else pcnt++;
      end
    end else if (n_astrb && n_dstrb && n_wait) begin
      if (mode != 2) begin
        if (pcnt >= dly) begin pcnt = 0; n_wait = 0; end
        else pcnt++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [2:0] a, input logic [1:0] s,
                     input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    while (!ready) @(negedge clk);
    nlog = 0;
    req = 1; we = w; addr = a; size = s; wdata = d;
    @(negedge clk);
    req = 0;
    while (!ack) @(negedge clk);
    r = rdata;
  endtask

  function automatic logic [31:0] ones_w(input logic [2:0] a, input logic [1:0] s);
    if (a == 3'd3 || s == 2'd0) return 32'h0000_00FF;
    if (s == 2'd1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic int nbytes(input logic [2:0] a, input logic [1:0] s);
    if (a == 3'd3 || s == 2'd0) return 1;
    if (s == 2'd1) return 2;
    return 4;
  endfunction

  task automatic tmo_is(input string tag, input logic e);
    logic [31:0] r;
    per_status = 8'($urandom);
    acc(0, 3'd1, 2'd0, 0, r);
    chk(tag, r, {24'h0, per_status[7:1], e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", {31'h0, ready}, 1);
    chk("R1 lines", {29'h0, n_write, n_astrb, n_dstrb}, 32'h7);
    acc(0, 3'd2, 2'd0, 0, r); chk("R1 ctrl", r, 32'hCC);
    tmo_is("R1 R8 status", 1'b0);

    acc(1, 3'd2, 2'd0, 32'h00, r); acc(0, 3'd2, 2'd0, 0, r); chk("R2 ctrl 00", r, 32'hC0);
    acc(1, 3'd2, 2'd0, 32'h3F, r); acc(0, 3'd2, 2'd0, 0, r); chk("R2 ctrl 3F", r, 32'hFF);

    acc(1, 3'd2, 2'd0, 32'h0C, r);
    acc(1, 3'd4, 2'd2, 32'hDEADBEEF, r); chk("R3 denied count", nlog, 0);
    tmo_is("R3 no flag", 1'b0);

    acc(1, 3'd2, 2'd0, 32'h04, r);
    acc(1, 3'd3, 2'd2, 32'h0000005A, r);
    chk("R6 addr one byte", nlog, 1);
    chk("R5 addr byte", {23'h0, log_a[0], log_w[0], log_b[0]}, {23'h0, 1'b1, 1'b0, 8'h5A});
    acc(1, 3'd4, 2'd2, 32'h11223344, r);
    chk("R6 wide write count", nlog, 4);
    chk("R6 wide write order", {log_b[3], log_b[2], log_b[1], log_b[0]}, 32'h11223344);
    chk("R5 data strobe", {31'h0, log_a[0]}, 0);

    acc(0, 3'd4, 2'd1, 0, r); chk("R4 denied 16", r, 32'h0000FFFF);
    acc(0, 3'd4, 2'd0, 0, r); chk("R4 denied 8", r, 32'h000000FF);
    acc(0, 3'd3, 2'd0, 0, r); chk("R4 denied addr", r, 32'h000000FF);
    acc(0, 3'd4, 2'd2, 0, r); chk("R4 denied 32", r, 32'hFFFFFFFF);
    chk("R4 denied count", nlog, 0);

    acc(1, 3'd2, 2'd0, 32'h24, r);
    acc(0, 3'd4, 2'd2, 0, r);
    chk("R6 wide read", r, {log_b[3], log_b[2], log_b[1], log_b[0]});
    acc(0, 3'd3, 2'd0, 0, r);
    chk("R5 addr read", {23'h0, log_a[0], log_w[0], 8'h0}, {23'h0, 1'b1, 1'b1, 8'h0});
    chk("R5 addr read data", r, {24'h0, log_b[0]});
    acc(0, 3'd0, 2'd0, 0, r); chk("R11 dir in", r, {24'h0, pd_in});
    acc(1, 3'd2, 2'd0, 32'h04, r);
    acc(1, 3'd0, 2'd0, 32'h77, r); acc(0, 3'd0, 2'd0, 0, r); chk("R11 dir out", r, 32'h77);

    mode = 1;
    acc(1, 3'd4, 2'd1, 32'hABCD, r);
    chk("R7 stuck low count", nlog, 0);
    tmo_is("R7 flag set", 1'b1);
    acc(1, 3'd1, 2'd0, 32'hFE, r);
    tmo_is("R9 no clear", 1'b1);
    mode = 2;
    acc(1, 3'd4, 2'd2, 32'h01020304, r);
    chk("R7 abort rest", nlog, 1);
    mode = 0; repeat (8) @(negedge clk);
    acc(1, 3'd2, 2'd0, 32'h24, r);
    mode = 2;
    acc(0, 3'd4, 2'd2, 0, r);
    chk("R7 partial read", r, {24'hFFFFFF, log_b[0]});
    mode = 0; repeat (8) @(negedge clk);
    acc(1, 3'd1, 2'd0, 32'h01, r);
    tmo_is("R9 clear", 1'b0);

    acc(1, 3'd2, 2'd0, 32'h04, r);
    mode = 1;
    @(negedge clk);
    req = 1; we = 1; addr = 3'd4; size = 0; wdata = 32'hAB;
    @(negedge clk);
    req = 0;
    chk("R10 busy", {31'h0, ready}, 0);
    req = 1; we = 1; addr = 3'd2; wdata = 32'h00;
    @(negedge clk); @(negedge clk);
    req = 0;
    while (!ack) @(negedge clk);
    mode = 0; repeat (4) @(negedge clk);
    acc(0, 3'd2, 2'd0, 0, r); chk("R10 ignored write", r, 32'hC4);
    acc(1, 3'd1, 2'd0, 32'h01, r);

    for (int i = 0; i < 60; i++) begin
      logic [7:0] c; logic w; logic [2:0] a; logic [1:0] s;
      logic [31:0] d, e; logic ok; int nb;
      case ($urandom % 3)
        0: c = 8'h04;
        1: c = 8'h24;
        default: c = 8'($urandom);
      endcase
      w = 1'($urandom); a = ($urandom % 2) ? 3'd3 : 3'd4;
      s = 2'($urandom % 3); d = $urandom; dly = $urandom % 4;
      acc(1, 3'd2, 2'd0, {24'h0, c}, r);
      acc(w, a, s, d, r);
      ok = w ? ((c & 8'h2F) == 8'h04) : ((c & 8'h2F) == 8'h24);
      nb = ok ? nbytes(a, s) : 0;
      chk(w ? "R3 rand count" : "R4 rand count", nlog, nb);
      e = ones_w(a, s);
      for (int k = 0; k < nb && k < 8; k++) begin
        chk("R5 rand strobe", {30'h0, log_a[k], log_w[k]}, {30'h0, a == 3'd3, !w});
        if (w) chk("R6 rand wbyte", {24'h0, log_b[k]}, {24'h0, d[k*8 +: 8]});
        else e[k*8 +: 8] = log_b[k];
      end
      if (!w) chk("R6 rand rdata", r, e);
      if (i % 10 == 0) tmo_is("R8 rand status", 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule